// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a single serial bit stream, one bit per clock, and groups it into consecutive frames of three bits. Frames follow one another with no gap and no overlap. The first sampled bit after reset starts a frame. The block raises its detect flag while the last bit of a frame is present, when that frame is `010` or `110`. Put another way, the middle bit is 1 and the last bit is 0, and the first bit does not matter.

The control is a four-state Mealy machine. It has one state for each of the first two bit positions. For the third position it has two states, and these keep only the value of the middle bit. The detect flag is combinational from the present state and the current input bit. A registered copy is also provided, one cycle later, for consumers that need a flop-driven signal. The parameter `REG_OUT` selects whether that copy is registered (1, the default) or a plain wire copy of the flag (0).

Top module: `frame3_detect`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) returns the machine to its frame-start state. The first bit sampled with `rst` low is bit one of a new frame, and `hit` is 0 while that bit is presented.
- R2: While the third bit of a frame is presented, `hit` is 1 exactly when that bit is 0 and the frame's second bit was 1. The frames `010` and `110` are written first bit first.
- R3: `hit` is 0 while the first or second bit of any frame is presented, whatever the input value.
- R4: Frames do not overlap. After every third bit the next sampled bit is the first bit of a new frame, so a `0` following a `01` that straddles a frame boundary raises no detect.
- R5: With `REG_OUT`=1, `hit_q` equals the value `hit` had in the previous cycle, and `hit_q` is 0 in the cycle after a reset edge.
- R6: The frames `000`, `001`, `011`, `100`, `101` and `111` never raise `hit` on any of their bits.
- R7: A reset applied part-way through a frame drops the partial frame. Bits already taken in have no effect on the frame that starts after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit, one per cycle |
| hit | output | 1 | Combinational detect flag for the current third bit |
| hit_q | output | 1 | Detect flag delayed one cycle (registered when REG_OUT=1) |

## Verification
The assertions assume that `bit_in` is a defined 0 or 1 at every rising edge with `rst` low. They also assume that every cycle with `rst` low carries a real data bit, because the block has no valid strobe and counts frame positions by cycles alone. The stimulus drives `bit_in` and `rst` only at falling edges, from an exhaustive sweep of the eight frame patterns, a long pseudo-random bit stream and mid-frame resets. It never leaves a cycle idle or undefined, so the checker's own frame-position counter stays aligned with the design.

// File: rtl/frame3_detect.sv
module frame3_detect #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit,
  output logic hit_q
);

  typedef enum logic [1:0] {
    ST_POS1    = 2'd0,
    ST_POS2    = 2'd1,
    ST_POS3_LO = 2'd2,
    ST_POS3_HI = 2'd3
  } pos_t;

  pos_t st, st_nx;

  always_comb begin
    unique case (st)
      ST_POS1:    st_nx = ST_POS2;
      ST_POS2:    st_nx = bit_in ? ST_POS3_HI : ST_POS3_LO;
      default:    st_nx = ST_POS1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_POS1;
    else     st <= st_nx;
  end

  assign hit = (st == ST_POS3_HI) && !bit_in;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) hit_q <= 1'b0;
        else     hit_q <= hit;
      end
    end else begin : g_wire
      assign hit_q = hit;
    end
  endgenerate

endmodule

// File: rtl/frame3_detect_chk.sv
module frame3_detect_chk #(
  parameter bit REG_OUT = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic bit_in,
  input logic hit,
  input logic hit_q
);

  logic [1:0] pos;
  logic       mid;
  logic       rst_d;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      pos <= 2'd0;
      mid <= 1'b0;
    end else begin
      pos <= (pos == 2'd2) ? 2'd0 : pos + 2'd1;
      if (pos == 2'd1) mid <= bit_in;
    end
  end

  AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !hit);  // R1

  AST_THIRD_DECODE: assert property (@(posedge clk) disable iff (rst)
    (!rst_d && pos == 2'd2) |-> (hit == (mid && !bit_in)));  // R2

  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pos != 2'd2) |-> !hit);  // R3

  generate
    if (REG_OUT) begin : g_q
      AST_DELAY_COPY: assert property (@(posedge clk) disable iff (rst)
        !rst_d |-> (hit_q == $past(hit)));  // R5

      AST_DELAY_CLEAR: assert property (@(posedge clk) disable iff (rst)
        rst_d |-> !hit_q);  // R5
    end
  endgenerate

endmodule

bind frame3_detect frame3_detect_chk #(.REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_frame3_detect.sv
`timescale 1ns/1ps
module sim_frame3_detect;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit, hit_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_pos = 0;
  bit m_mid = 1'b0;
  bit m_q = 1'b0;
  bit m_rst_d = 1'b1;

  always #5 clk = ~clk;

  frame3_detect u0 (.clk(clk), .rst(rst), .bit_in(bit_in), .hit(hit), .hit_q(hit_q));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive at falling edge, check, then advance the model across the rising edge.
  task automatic cyc(input logic b, input logic r, input string tag);
    bit e_hit;
    rst = r;
    bit_in = b;
    #1;
    e_hit = (m_pos == 2) && m_mid && !b;
    if (!r) begin
      if (m_rst_d) chk({tag, " R1 first bit after reset"}, hit, 1'b0);
      else if (m_pos == 2) chk({tag, " R2 third-bit decode"}, hit, e_hit);
      else chk({tag, " R3 early bit quiet"}, hit, 1'b0);
      chk({tag, " R5 delayed copy"}, hit_q, m_q);
    end
    @(posedge clk);
    m_rst_d = r;
    if (r) begin
      m_pos = 0;
      m_q = 1'b0;
    end else begin
      m_q = e_hit;
      if (m_pos == 1) m_mid = b;
      m_pos = (m_pos == 2) ? 0 : m_pos + 1;
    end
    @(negedge clk);
  endtask

  task automatic frame(input logic [2:0] f, input string tag);
    cyc(f[2], 1'b0, tag);
    cyc(f[1], 1'b0, tag);
    cyc(f[0], 1'b0, tag);
  endtask

  initial begin
    @(negedge clk);
    cyc(1'b1, 1'b1, "reset");
    cyc(1'b0, 1'b1, "reset");
    // R1: first frame after reset, lone 0 would be a detect if misaligned
    cyc(1'b0, 1'b0, "R1");
    chk("R5 hit_q clear after reset", hit_q, 1'b0);
    cyc(1'b1, 1'b0, "R1");
    cyc(1'b0, 1'b0, "R1");

    // R2 / R6: every frame pattern, twice
    for (int k = 0; k < 16; k++)
      frame(k[2:0], (k[2:0] == 3'b010 || k[2:0] == 3'b110) ? "R2" : "R6");

    // R4: 01 straddling a boundary: frames 101 then 0xx
    frame(3'b101, "R4");
    frame(3'b011, "R4");
    frame(3'b001, "R4");
    cyc(1'b0, 1'b0, "R4");
    cyc(1'b1, 1'b0, "R4");
    cyc(1'b0, 1'b0, "R4");

    // R7: reset after second bit 1, then a third-bit 0 must not detect
    cyc(1'b0, 1'b0, "R7");
    cyc(1'b1, 1'b0, "R7");
    cyc(1'b0, 1'b1, "R7");
    frame(3'b000, "R7");
    cyc(1'b1, 1'b0, "R7");
    cyc(1'b0, 1'b1, "R7");
    frame(3'b110, "R7");

    // R4: long pseudo-random stream
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int n = 0; n < 900; n++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cyc(lfsr[0], (n % 211) == 200, "R4 stream");
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule